// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a NOR-style flash macro and interprets its stream of bus-write events. Each write carries an address and a data word. The block counts the unlock prefixes (AAh at 555h, then 55h at 2AAh) that guard every multi-write command. From them it derives single-cycle request pulses for a downstream program/erase controller: word program, paired-word program, chip erase, block erase, suspend and resume.

It also keeps the nested read modes: identifier read, the parameter-query area, unlock bypass and extended-block redirection. From these it tells the read path which source to return. In identifier mode it supplies the identifier word for the current read address. It works out the protection of any block from a hardware write-protect pin, a temporary-unprotect pin and a per-block lock vector. It drops program and erase requests aimed at protected blocks without any error indication.

Any write that breaks a sequence sends the decoder back to array read. The boot block is the highest block by default, or the lowest when the `BOOT_HIGH` parameter is 0.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_sel is 0 (array), bypass_on and ext_on are low, and no request pulse is active.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by an address/data write raise prog_go for exactly the cycle after that last write, with prog_addr and prog_data equal to it. A sequence broken by a wrong value returns to array read and starts nothing.
- R3: Writing AAh@555h, 55h@2AAh, 90h@555h sets rd_sel to 1. rd_id_data then depends on rd_addr[1:0]. 00 gives 0020h and 01 gives 22C7h. 10 gives 0001h if the block at rd_addr[21:15] is protected, otherwise 0000h. 11 gives 0000h.
- R4: In identifier mode, only read/reset (F0h) and the query command are acted on. A program sequence starts nothing and leaves rd_sel at 1. F0h returns rd_sel to 0.
- R5: A single write of 98h at 55h from array read or identifier mode sets rd_sel to 2. F0h then restores the mode that was active before the query.
- R6: A block is protected when wp_n is low and it is the boot block, whatever tmp_unprot says. It is also protected when its blk_lock bit is set and tmp_unprot is low. A program to a protected block produces no pulse.
- R7: AAh@555h, 55h@2AAh, 20h@555h sets bypass_on. In bypass, A0h plus one address/data write programs. F0h does not leave bypass; only 90h followed by 00h does. hv_prog high forces bypass_on.
- R8: AAh@555h, 55h@2AAh, 50h@555h followed by two address/data writes raises prog_go with prog_dw high, but only if the two addresses differ in bit 0 alone. prog_data2 carries the second word. Otherwise nothing starts.
- R9: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh then 10h@555h raises erase_go with erase_chip high. Ending with 30h at a block address raises erase_go with erase_blk equal to address bits 21:15, unless that block is protected.
- R10: AAh@555h, 55h@2AAh, 88h@555h sets ext_on. While ext_on is high, boot-block reads raise rd_ext and boot-block programs carry prog_ext and skip the protection check. Chip erase and boot-block erase are dropped. AAh, 55h, 90h, 00h clears ext_on.
- R11: While ctl_busy is high and ctl_suspended is low, rd_sel is 3 and writes are ignored, except that B0h while ctl_erasing is high raises susp_go. With ctl_suspended high, 30h raises resume_go.
- R12: An F0h write between the cycles of an unfinished sequence abandons it and returns to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | One-cycle bus-write event |
| wr_addr | input | 22 | Write address |
| wr_data | input | 16 | Write data; command code in bits 7:0 |
| rd_addr | input | 22 | Current read address |
| wp_n | input | 1 | Low protects the boot block |
| tmp_unprot | input | 1 | High lifts lock-vector protection |
| hv_prog | input | 1 | High-voltage program flag, forces bypass |
| blk_lock | input | 128 | Per-block lock bits |
| ctl_busy | input | 1 | Controller running an operation |
| ctl_erasing | input | 1 | Running operation is an erase |
| ctl_suspended | input | 1 | Erase is suspended |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| rd_id_data | output | 16 | Identifier word for rd_addr |
| rd_ext | output | 1 | Array read redirected to extended block |
| prog_go | output | 1 | Program request pulse |
| prog_dw | output | 1 | Request is a paired-word program |
| prog_addr | output | 22 | Program address |
| prog_data | output | 16 | Program data |
| prog_data2 | output | 16 | Second word of a paired program |
| prog_ext | output | 1 | Program targets the extended block |
| erase_go | output | 1 | Erase request pulse |
| erase_chip | output | 1 | Erase is whole-chip |
| erase_blk | output | 7 | Block to erase |
| susp_go | output | 1 | Suspend request pulse |
| resume_go | output | 1 | Resume request pulse |
| bypass_on | output | 1 | Unlock bypass active |
| ext_on | output | 1 | Extended-block mode active |

## Verification
The assertions check five rules on every cycle:
- every program or erase pulse follows an accepted write to an unprotected target, unless the target is redirected;
- a paired program's two addresses differ only in bit 0;
- bypass is left only through its own exit state;
- a suspend pulse only follows a write made during an erase;
- a chip erase never starts with extended mode active.

What the assertions cannot show is that each command needs exactly its own number of writes, that the returns from query mode nest correctly, that the identifier words are right, and that ignored commands really have no effect. The directed scenarios show these at the ports.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_U1, S_U2, S_PGM, S_DW1, S_DW2,
      S_ER3, S_ER4, S_ER5, S_BPGM, S_BRST, S_XEXIT
   } seq_e;

   localparam logic [1:0] RD_ARRAY  = 2'd0;
   localparam logic [1:0] RD_ID     = 2'd1;
   localparam logic [1:0] RD_QUERY  = 2'd2;
   localparam logic [1:0] RD_STATUS = 2'd3;

   localparam logic [7:0] C_UNLK1  = 8'hAA;
   localparam logic [7:0] C_UNLK2  = 8'h55;
   localparam logic [7:0] C_RESET  = 8'hF0;
   localparam logic [7:0] C_IDENT  = 8'h90;
   localparam logic [7:0] C_QUERY  = 8'h98;
   localparam logic [7:0] C_PROG   = 8'hA0;
   localparam logic [7:0] C_DWPROG = 8'h50;
   localparam logic [7:0] C_BYPASS = 8'h20;
   localparam logic [7:0] C_ERSET  = 8'h80;
   localparam logic [7:0] C_CHIP   = 8'h10;
   localparam logic [7:0] C_BLKER  = 8'h30;
   localparam logic [7:0] C_SUSP   = 8'hB0;
   localparam logic [7:0] C_RESUME = 8'h30;
   localparam logic [7:0] C_EXTIN  = 8'h88;
   localparam logic [7:0] C_ZERO   = 8'h00;

   localparam int UA_W = 11;
   localparam logic [UA_W-1:0] A_555 = 11'h555;
   localparam logic [UA_W-1:0] A_2AA = 11'h2AA;
   localparam logic [UA_W-1:0] A_055 = 11'h055;
endpackage

// File: rtl/fcd_prot.sv
module fcd_prot #(
   parameter int AW        = 22,
   parameter int BLK_LSB   = 15,
   parameter bit BOOT_HIGH = 1'b1,
   localparam int BW   = AW - BLK_LSB,
   localparam int NBLK = 1 << BW
) (
   input  logic [BW-1:0]   blk,
   input  logic            wp_n,
   input  logic            tmp_unprot,
   input  logic [NBLK-1:0] blk_lock,
   output logic            is_boot,
   output logic            is_prot
);
   logic [BW-1:0] boot_idx;

   generate
      if (BOOT_HIGH) begin : g_boot_top
         assign boot_idx = BW'(NBLK - 1);
      end else begin : g_boot_bottom
         assign boot_idx = '0;
      end
   endgenerate

   assign is_boot = (blk == boot_idx);
   assign is_prot = (is_boot && !wp_n) || (blk_lock[blk] && !tmp_unprot);
endmodule

// File: rtl/fcd_idcode.sv
module fcd_idcode #(
   parameter int          DW     = 16,
   parameter logic [15:0] MFR_ID = 16'h0020,
   parameter logic [15:0] DEV_ID = 16'h22C7
) (
   input  logic [1:0]    sel,
   input  logic          blk_prot,
   output logic [DW-1:0] id_word
);
   generate
      if (DW < 16) begin : g_bad_dw
         $error("fcd_idcode: DW must be at least 16");
      end
   endgenerate

   always_comb begin
      id_word = '0;
      unique case (sel)
         2'b00: id_word = DW'(MFR_ID);
         2'b01: id_word = DW'(DEV_ID);
         2'b10: id_word = DW'({15'd0, blk_prot});
         default: id_word = '0;
      endcase
   end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
   import fcd_pkg::*;
#(
   parameter int AW      = 22,
   parameter int DW      = 16,
   parameter int BLK_LSB = 15,
   localparam int BW = AW - BLK_LSB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_prot,
   input  logic          wr_boot,
   input  logic          hv_prog,
   input  logic          ctl_busy,
   input  logic          ctl_erasing,
   input  logic          ctl_suspended,
   output logic          mode_id,
   output logic          mode_query,
   output logic          bypass_on,
   output logic          ext_on,
   output logic          prog_go,
   output logic          prog_dw,
   output logic [AW-1:0] prog_addr,
   output logic [DW-1:0] prog_data,
   output logic [DW-1:0] prog_data2,
   output logic          prog_ext,
   output logic          erase_go,
   output logic          erase_chip,
   output logic [BW-1:0] erase_blk,
   output logic          susp_go,
   output logic          resume_go
);
   generate
      if (AW < UA_W + 1) begin : g_bad_aw
         $error("fcd_seq: address too narrow for unlock decode");
      end
   endgenerate

   seq_e          st_q, st_d;
   logic          id_q, id_d, qry_q, qry_d, byp_q, byp_d, ext_q, ext_d;
   logic [AW-1:0] ladr_q, ladr_d, padr_d;
   logic [DW-1:0] ldat_q, ldat_d, pdat_d, pdat2_d;
   logic          pg_d, pdw_d, pext_d, eg_d, ech_d, sg_d, rg_d;
   logic [BW-1:0] eblk_d;

   logic [7:0] cmd;
   logic       at555, at2aa, at055, run, byp, redir, data_st, pair_ok;

   assign cmd     = wr_data[7:0];
   assign at555   = (wr_addr[UA_W-1:0] == A_555);
   assign at2aa   = (wr_addr[UA_W-1:0] == A_2AA);
   assign at055   = (wr_addr[UA_W-1:0] == A_055);
   assign run     = ctl_busy && !ctl_suspended;
   assign byp     = byp_q || hv_prog;
   assign redir   = ext_q && wr_boot;
   assign data_st = (st_q == S_PGM) || (st_q == S_DW1) ||
                    (st_q == S_DW2) || (st_q == S_BPGM);
   assign pair_ok = (wr_addr[AW-1:1] == ladr_q[AW-1:1]) &&
                    (wr_addr[0] != ladr_q[0]);

   always_comb begin
      st_d = st_q; id_d = id_q; qry_d = qry_q; byp_d = byp_q; ext_d = ext_q;
      ladr_d = ladr_q; ldat_d = ldat_q;
      pg_d = 1'b0; pdw_d = 1'b0; eg_d = 1'b0; sg_d = 1'b0; rg_d = 1'b0;
      padr_d = prog_addr; pdat_d = prog_data; pdat2_d = prog_data2;
      pext_d = prog_ext; ech_d = erase_chip; eblk_d = erase_blk;
      if (wr_stb) begin
         if (run) begin
            if (ctl_erasing && cmd == C_SUSP) sg_d = 1'b1;
         end else if (cmd == C_RESET && !data_st) begin
            st_d = S_IDLE;
            if (qry_q) qry_d = 1'b0;
            else       id_d  = 1'b0;
         end else if (cmd == C_QUERY && at055 && st_q == S_IDLE &&
                      !qry_q && !byp) begin
            qry_d = 1'b1;
         end else if (qry_q) begin
            st_d = S_IDLE;
         end else if (ctl_suspended && cmd == C_RESUME &&
                      st_q == S_IDLE && !byp) begin
            rg_d = 1'b1;
         end else begin
            st_d = S_IDLE;
            unique case (st_q)
               S_IDLE: begin
                  if (byp) begin
                     if (cmd == C_PROG)       st_d = S_BPGM;
                     else if (cmd == C_IDENT) st_d = S_BRST;
                  end else if (cmd == C_UNLK1 && at555) begin
                     st_d = S_U1;
                  end
               end
               S_U1: if (cmd == C_UNLK2 && at2aa) st_d = S_U2;
               S_U2: begin
                  if (at555 && !id_q) begin
                     unique case (cmd)
                        C_IDENT:  if (ext_q) st_d = S_XEXIT; else id_d = 1'b1;
                        C_PROG:   st_d = S_PGM;
                        C_DWPROG: st_d = S_DW1;
                        C_BYPASS: byp_d = 1'b1;
                        C_ERSET:  if (!ctl_suspended) st_d = S_ER3;
                        C_EXTIN:  ext_d = 1'b1;
                        default:  st_d = S_IDLE;
                     endcase
                  end
               end
               S_PGM, S_BPGM: begin
                  if (redir || !wr_prot) begin
                     pg_d = 1'b1; padr_d = wr_addr; pdat_d = wr_data;
                     pext_d = redir;
                  end
               end
               S_DW1: begin
                  ladr_d = wr_addr; ldat_d = wr_data; st_d = S_DW2;
               end
               S_DW2: begin
                  if (pair_ok && (redir || !wr_prot)) begin
                     pg_d = 1'b1; pdw_d = 1'b1; padr_d = ladr_q;
                     pdat_d = ldat_q; pdat2_d = wr_data; pext_d = redir;
                  end
               end
               S_ER3: if (cmd == C_UNLK1 && at555) st_d = S_ER4;
               S_ER4: if (cmd == C_UNLK2 && at2aa) st_d = S_ER5;
               S_ER5: begin
                  if (cmd == C_CHIP && at555) begin
                     if (!ext_q) begin eg_d = 1'b1; ech_d = 1'b1; end
                  end else if (cmd == C_BLKER) begin
                     if (!wr_prot && !redir) begin
                        eg_d = 1'b1; ech_d = 1'b0;
                        eblk_d = wr_addr[AW-1:BLK_LSB];
                     end
                  end
               end
               S_BRST:  if (cmd == C_ZERO) byp_d = 1'b0;
               S_XEXIT: if (cmd == C_ZERO) ext_d = 1'b0;
               default: st_d = S_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE; id_q <= 1'b0; qry_q <= 1'b0; byp_q <= 1'b0; ext_q <= 1'b0;
         ladr_q <= '0; ldat_q <= '0;
         prog_go <= 1'b0; prog_dw <= 1'b0; prog_addr <= '0; prog_data <= '0;
         prog_data2 <= '0; prog_ext <= 1'b0; erase_go <= 1'b0;
         erase_chip <= 1'b0; erase_blk <= '0; susp_go <= 1'b0; resume_go <= 1'b0;
      end else begin
         st_q <= st_d; id_q <= id_d; qry_q <= qry_d; byp_q <= byp_d; ext_q <= ext_d;
         ladr_q <= ladr_d; ldat_q <= ldat_d;
         prog_go <= pg_d; prog_dw <= pdw_d; prog_addr <= padr_d;
         prog_data <= pdat_d; prog_data2 <= pdat2_d; prog_ext <= pext_d;
         erase_go <= eg_d; erase_chip <= ech_d; erase_blk <= eblk_d;
         susp_go <= sg_d; resume_go <= rg_d;
      end
   end

   assign mode_id    = id_q;
   assign mode_query = qry_q;
   assign bypass_on  = byp;
   assign ext_on     = ext_q;

   // R2
   prog_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> $past(wr_stb));
   // R6
   prog_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go && !prog_ext) |-> ($past(wr_prot) == 1'b0));
   // R8
   pair_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go && prog_dw) |->
      ($past(wr_addr[AW-1:1]) == prog_addr[AW-1:1] && $past(wr_addr[0]) != prog_addr[0]));
   // R7
   bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(byp_q) |-> ($past(st_q) == S_BRST));
   // R9
   erase_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_go && !erase_chip) |-> ($past(wr_prot) == 1'b0));
   // R10
   chip_erase_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_go && erase_chip) |-> !ext_q);
   // R11
   susp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp_go |-> $past(ctl_erasing && wr_stb));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int          AW        = 22,
   parameter int          DW        = 16,
   parameter int          BLK_LSB   = 15,
   parameter bit          BOOT_HIGH = 1'b1,
   parameter logic [15:0] MFR_ID    = 16'h0020,
   parameter logic [15:0] DEV_ID    = 16'h22C7,
   localparam int BW   = AW - BLK_LSB,
   localparam int NBLK = 1 << BW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_stb,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [AW-1:0]   rd_addr,
   input  logic            wp_n,
   input  logic            tmp_unprot,
   input  logic            hv_prog,
   input  logic [NBLK-1:0] blk_lock,
   input  logic            ctl_busy,
   input  logic            ctl_erasing,
   input  logic            ctl_suspended,
   output logic [1:0]      rd_sel,
   output logic [DW-1:0]   rd_id_data,
   output logic            rd_ext,
   output logic            prog_go,
   output logic            prog_dw,
   output logic [AW-1:0]   prog_addr,
   output logic [DW-1:0]   prog_data,
   output logic [DW-1:0]   prog_data2,
   output logic            prog_ext,
   output logic            erase_go,
   output logic            erase_chip,
   output logic [BW-1:0]   erase_blk,
   output logic            susp_go,
   output logic            resume_go,
   output logic            bypass_on,
   output logic            ext_on
);
   generate
      if (BLK_LSB < 3 || BLK_LSB >= AW) begin : g_bad_blk
         $error("flash_cmd_decoder: BLK_LSB out of range");
      end
      if (BW > 12) begin : g_bad_bw
         $error("flash_cmd_decoder: too many blocks");
      end
   endgenerate

   logic wr_prot, wr_boot, rd_prot, rd_boot, mode_id, mode_query;
   logic unused_rd_mid;
   assign unused_rd_mid = ^rd_addr[BLK_LSB-1:2];

   fcd_prot #(.AW(AW), .BLK_LSB(BLK_LSB), .BOOT_HIGH(BOOT_HIGH)) u_wr_prot (
      .blk(wr_addr[AW-1:BLK_LSB]), .wp_n(wp_n), .tmp_unprot(tmp_unprot),
      .blk_lock(blk_lock), .is_boot(wr_boot), .is_prot(wr_prot));

   fcd_prot #(.AW(AW), .BLK_LSB(BLK_LSB), .BOOT_HIGH(BOOT_HIGH)) u_rd_prot (
      .blk(rd_addr[AW-1:BLK_LSB]), .wp_n(wp_n), .tmp_unprot(tmp_unprot),
      .blk_lock(blk_lock), .is_boot(rd_boot), .is_prot(rd_prot));

   fcd_idcode #(.DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
      .sel(rd_addr[1:0]), .blk_prot(rd_prot), .id_word(rd_id_data));

   fcd_seq #(.AW(AW), .DW(DW), .BLK_LSB(BLK_LSB)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_prot(wr_prot), .wr_boot(wr_boot),
      .hv_prog(hv_prog), .ctl_busy(ctl_busy), .ctl_erasing(ctl_erasing),
      .ctl_suspended(ctl_suspended), .mode_id(mode_id), .mode_query(mode_query),
      .bypass_on(bypass_on), .ext_on(ext_on), .prog_go(prog_go),
      .prog_dw(prog_dw), .prog_addr(prog_addr), .prog_data(prog_data),
      .prog_data2(prog_data2), .prog_ext(prog_ext), .erase_go(erase_go),
      .erase_chip(erase_chip), .erase_blk(erase_blk), .susp_go(susp_go),
      .resume_go(resume_go));

   always_comb begin
      if (ctl_busy && !ctl_suspended) rd_sel = RD_STATUS;
      else if (mode_query)            rd_sel = RD_QUERY;
      else if (mode_id)               rd_sel = RD_ID;
      else                            rd_sel = RD_ARRAY;
   end

   assign rd_ext = ext_on && rd_boot && (rd_sel == RD_ARRAY);

   // R5
   query_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_query && !ctl_busy) |-> (rd_sel == RD_QUERY));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_stb = 1'b0;
   logic [21:0] wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic wp_n = 1'b1, tmp_unprot = 1'b0, hv_prog = 1'b0;
   logic [127:0] blk_lock = '0;
   logic ctl_busy = 1'b0, ctl_erasing = 1'b0, ctl_suspended = 1'b0;
   logic [1:0] rd_sel;
   logic [15:0] rd_id_data, prog_data, prog_data2;
   logic [21:0] prog_addr;
   logic [6:0] erase_blk;
   logic rd_ext, prog_go, prog_dw, prog_ext, erase_go, erase_chip;
   logic susp_go, resume_go, bypass_on, ext_on;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .wp_n(wp_n),
      .tmp_unprot(tmp_unprot), .hv_prog(hv_prog), .blk_lock(blk_lock),
      .ctl_busy(ctl_busy), .ctl_erasing(ctl_erasing),
      .ctl_suspended(ctl_suspended), .rd_sel(rd_sel), .rd_id_data(rd_id_data),
      .rd_ext(rd_ext), .prog_go(prog_go), .prog_dw(prog_dw),
      .prog_addr(prog_addr), .prog_data(prog_data), .prog_data2(prog_data2),
      .prog_ext(prog_ext), .erase_go(erase_go), .erase_chip(erase_chip),
      .erase_blk(erase_blk), .susp_go(susp_go), .resume_go(resume_go),
      .bypass_on(bypass_on), .ext_on(ext_on));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one write; returns at the negedge where request pulses are visible
   task automatic wr(input logic [21:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic unlock();
      wr(22'h555, 16'hAA);
      wr(22'h2AA, 16'h55);
   endtask

   task automatic rd(input logic [21:0] a);
      rd_addr = a; #1;
   endtask

   task automatic t_reset();
      chk("R1 rd_sel", 32'(rd_sel), 0);
      chk("R1 bypass", 32'(bypass_on), 0);
      chk("R1 ext", 32'(ext_on), 0);
      chk("R1 pulses", 32'({prog_go, erase_go, susp_go, resume_go}), 0);
   endtask

   task automatic t_program();
      unlock(); wr(22'h555, 16'hA0); wr(22'h001234, 16'hBEEF);
      chk("R2 go", 32'(prog_go), 1);
      chk("R2 addr", 32'(prog_addr), 32'h001234);
      chk("R2 data", 32'(prog_data), 32'hBEEF);
      chk("R2 dw", 32'(prog_dw), 0);
      wr(22'h555, 16'hAA); wr(22'h2AA, 16'h12); wr(22'h555, 16'hA0);
      wr(22'h000040, 16'h1111);
      chk("R2 broken", 32'(prog_go), 0);
   endtask

   task automatic t_ident();
      blk_lock[5] = 1'b1;
      unlock(); wr(22'h555, 16'h90);
      chk("R3 sel", 32'(rd_sel), 1);
      rd(22'h0); chk("R3 mfr", 32'(rd_id_data), 32'h0020);
      rd(22'h1); chk("R3 dev", 32'(rd_id_data), 32'h22C7);
      rd({7'd5, 15'h2}); chk("R3 prot", 32'(rd_id_data), 1);
      rd({7'd6, 15'h2}); chk("R3 unprot", 32'(rd_id_data), 0);
      rd(22'h3); chk("R3 other", 32'(rd_id_data), 0);
      unlock(); wr(22'h555, 16'hA0); wr(22'h000100, 16'h2222);
      chk("R4 no prog", 32'(prog_go), 0);
      chk("R4 stays", 32'(rd_sel), 1);
      wr(22'h0, 16'hF0);
      chk("R4 exit", 32'(rd_sel), 0);
      blk_lock[5] = 1'b0;
   endtask

   task automatic t_query();
      wr(22'h055, 16'h98); chk("R5 enter", 32'(rd_sel), 2);
      wr(22'h0, 16'hF0);   chk("R5 back array", 32'(rd_sel), 0);
      unlock(); wr(22'h555, 16'h90);
      wr(22'h055, 16'h98); chk("R5 from id", 32'(rd_sel), 2);
      wr(22'h0, 16'hF0);   chk("R5 back id", 32'(rd_sel), 1);
      wr(22'h0, 16'hF0);   chk("R5 back array2", 32'(rd_sel), 0);
   endtask

   task automatic t_prot();
      blk_lock[5] = 1'b1;
      unlock(); wr(22'h555, 16'hA0); wr({7'd5, 15'h10}, 16'h3);
      chk("R6 locked", 32'(prog_go), 0);
      tmp_unprot = 1'b1;
      unlock(); wr(22'h555, 16'hA0); wr({7'd5, 15'h10}, 16'h3);
      chk("R6 unprot", 32'(prog_go), 1);
      wp_n = 1'b0;
      unlock(); wr(22'h555, 16'hA0); wr({7'd127, 15'h10}, 16'h3);
      chk("R6 wp boot", 32'(prog_go), 0);
      unlock(); wr(22'h555, 16'h90);
      rd({7'd127, 15'h2}); chk("R6 wp status", 32'(rd_id_data), 1);
      wr(22'h0, 16'hF0);
      wp_n = 1'b1; tmp_unprot = 1'b0; blk_lock[5] = 1'b0;
   endtask

   task automatic t_bypass();
      unlock(); wr(22'h555, 16'h20);
      chk("R7 enter", 32'(bypass_on), 1);
      wr(22'h0, 16'hA0); wr(22'h000200, 16'h4444);
      chk("R7 prog", 32'(prog_go), 1);
      chk("R7 data", 32'(prog_data), 32'h4444);
      wr(22'h0, 16'hF0);
      chk("R7 reset keeps", 32'(bypass_on), 1);
      wr(22'h0, 16'h90); wr(22'h0, 16'h00);
      chk("R7 exit", 32'(bypass_on), 0);
      hv_prog = 1'b1; #1;
      chk("R7 hv", 32'(bypass_on), 1);
      wr(22'h0, 16'hA0); wr(22'h000300, 16'h5555);
      chk("R7 hv prog", 32'(prog_go), 1);
      hv_prog = 1'b0;
   endtask

   task automatic t_pair();
      unlock(); wr(22'h555, 16'h50); wr(22'h000100, 16'h0001); wr(22'h000101, 16'h0002);
      chk("R8 go", 32'({prog_go, prog_dw}), 3);
      chk("R8 addr", 32'(prog_addr), 32'h100);
      chk("R8 data", 32'({prog_data, prog_data2}), 32'h00010002);
      unlock(); wr(22'h555, 16'h50); wr(22'h000100, 16'h0001); wr(22'h000103, 16'h0002);
      chk("R8 mismatch", 32'(prog_go), 0);
   endtask

   task automatic erase_seq(input logic [21:0] a, input logic [15:0] c);
      unlock(); wr(22'h555, 16'h80); unlock(); wr(a, c);
   endtask

   task automatic t_erase();
      erase_seq(22'h555, 16'h10);
      chk("R9 chip", 32'({erase_go, erase_chip}), 3);
      erase_seq({7'd9, 15'h0}, 16'h30);
      chk("R9 blk go", 32'({erase_go, erase_chip}), 2);
      chk("R9 blk idx", 32'(erase_blk), 9);
      blk_lock[5] = 1'b1;
      erase_seq({7'd5, 15'h0}, 16'h30);
      chk("R9 locked", 32'(erase_go), 0);
      blk_lock[5] = 1'b0;
   endtask

   task automatic t_ext();
      unlock(); wr(22'h555, 16'h88);
      chk("R10 enter", 32'(ext_on), 1);
      rd({7'd127, 15'h4}); chk("R10 redirect", 32'(rd_ext), 1);
      rd({7'd0, 15'h4});   chk("R10 plain", 32'(rd_ext), 0);
      wp_n = 1'b0;
      unlock(); wr(22'h555, 16'hA0); wr({7'd127, 15'h8}, 16'h6);
      chk("R10 prog ext", 32'({prog_go, prog_ext}), 3);
      wp_n = 1'b1;
      erase_seq(22'h555, 16'h10);
      chk("R10 no chip", 32'(erase_go), 0);
      erase_seq({7'd127, 15'h0}, 16'h30);
      chk("R10 no boot erase", 32'(erase_go), 0);
      unlock(); wr(22'h555, 16'h90); wr(22'h0, 16'h00);
      chk("R10 exit", 32'(ext_on), 0);
   endtask

   task automatic t_busy();
      ctl_busy = 1'b1; ctl_erasing = 1'b1; #1;
      chk("R11 status", 32'(rd_sel), 3);
      unlock(); wr(22'h555, 16'hA0); wr(22'h000010, 16'h7);
      chk("R11 ignored", 32'(prog_go), 0);
      wr(22'h0, 16'hB0); chk("R11 suspend", 32'(susp_go), 1);
      ctl_suspended = 1'b1; #1;
      chk("R11 susp read", 32'(rd_sel), 0);
      wr(22'h0, 16'h30); chk("R11 resume", 32'(resume_go), 1);
      ctl_busy = 1'b0; ctl_erasing = 1'b0; ctl_suspended = 1'b0;
   endtask

   task automatic t_abort();
      wr(22'h555, 16'hAA); wr(22'h0, 16'hF0);
      wr(22'h2AA, 16'h55); wr(22'h555, 16'hA0); wr(22'h000020, 16'h8);
      chk("R12 abandoned", 32'(prog_go), 0);
      unlock(); wr(22'h555, 16'hA0); wr(22'h000020, 16'h8);
      chk("R12 recovers", 32'(prog_go), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset(); t_program(); t_ident(); t_query(); t_prot(); t_bypass();
      t_pair(); t_erase(); t_ext(); t_busy(); t_abort();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule